// File: doc/BRIEF.md
# Stuck-Cell-Aware Soft-Value Generator

This block sits between the read path of a two-bit-per-cell flash array and a soft-decision LDPC decoder. It takes one cell per transfer: a quantized read voltage, a flag that says whether the cell is known to be stuck, and a valid strobe. It turns each cell into two signed fixed-point log-likelihood ratios, one for each stored bit. Cells flagged as stuck do not pass on their read-derived values. Their two soft values are replaced by an erasure, so a stuck level that reads as a confident but wrong answer never reaches the decoder.

The voltage-to-LLR conversion is a table that software loads, indexed by voltage code, with one signed entry per bit. The table contents carry the Gray assignment of bit pairs to the four levels (lowest to highest: 00, 01, 11, 10). They also carry the noise weighting of each level, with variances in the ratio 4:1:1:2 from the lowest level up, so the block itself does not assume one common noise value. The erasure value is zero by default. A page can instead select a programmable bias, meant to hold a scaling factor times log 2, because the stuck channel is asymmetric. The erasure setting is captured at page start and holds for the whole page. The output is a valid/ready stream of single LLRs that emits the first bit of each pair before the second.

Top module: `llr_erase_gen`

## Requirements
- R1: For a cell whose stuck flag is 0 and voltage code c, the block emits table entry c for bit 0 (the first bit of the Gray pair, written through `lut_llr0_i`) and then table entry c for bit 1 (written through `lut_llr1_i`), each saturated as in R2.
- R2: Every emitted LLR lies in the range -127..+127. A value of -128, whether it comes from the table or from the bias, is emitted as -127.
- R3: A cell whose stuck flag is 1, when zero erasure is latched (bias mode 0), emits 0 for both bit positions.
- R4: A cell whose stuck flag is 1, when bias mode 1 is latched, emits the latched bias value (saturated as in R2) for both bit positions.
- R5: The bias mode and bias value are latched only in a cycle where `page_start_i` is 1. A cell accepted in that same cycle already uses the new setting. A change of `bias_en_i` or `bias_val_i` with no page start has no effect on later cells.
- R6: Each cell produces exactly two output transfers. The first has `llr_bit_o`=0 (bit 0) and the second has `llr_bit_o`=1 (bit 1).
- R7: While `llr_valid_o` is 1 and `llr_ready_i` is 0, `llr_o` and `llr_bit_o` hold steady. `cell_ready_o` is 0 while an undelivered pair is pending, so no cell is lost.
- R8: After reset, `llr_valid_o` is 0, `cell_ready_o` is 1, and the latched mode is zero erasure.
- R9: A table write takes effect for cells accepted from the next cycle on. A cell accepted in the same cycle as a write to its own code reads the previous entry.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_start_i | input | 1 | Latches the bias mode and value for the page |
| bias_en_i | input | 1 | Erasure mode to latch: 0 = zero, 1 = bias |
| bias_val_i | input | 8 | Signed bias value to latch |
| lut_we_i | input | 1 | Table write strobe |
| lut_addr_i | input | 6 | Table write address (voltage code) |
| lut_llr0_i | input | 8 | Signed table entry for bit 0 |
| lut_llr1_i | input | 8 | Signed table entry for bit 1 |
| cell_valid_i | input | 1 | Cell present |
| cell_ready_o | output | 1 | Cell can be accepted |
| cell_code_i | input | 6 | Quantized read voltage code |
| cell_stuck_i | input | 1 | Cell marked stuck |
| llr_valid_o | output | 1 | Output LLR present |
| llr_ready_i | input | 1 | Downstream accepts the LLR |
| llr_o | output | 8 | Signed saturated LLR |
| llr_bit_o | output | 1 | Bit position of `llr_o` within its cell |

## Verification
Two things can happen in the same cycle. A page start can arrive with a stuck cell, and a table write can target the code of the cell being accepted. The bench provokes the first by raising `page_start_i` with a new mode and a bias of -128 in the very cycle a stuck cell is taken. The cell must come out at -127 for both bits, which shows that the new setting applied at once and that saturation still took effect. The bench provokes the second by writing code 5 while a cell with code 5 is accepted. That cell must show the old entries, and the next cell with code 5 must show the new ones.

// File: rtl/llr_pkg.sv
package llr_pkg;
  localparam int unsigned CODE_W_DEF = 6;
  localparam int unsigned LLR_W_DEF  = 8;

  typedef enum logic {
    ERASE_ZERO = 1'b0,
    ERASE_BIAS = 1'b1
  } erase_mode_e;
endpackage

// File: rtl/llr_lut.sv
module llr_lut #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned LLR_W  = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [LLR_W-1:0]  wdata0_i,
  input  logic [LLR_W-1:0]  wdata1_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [LLR_W-1:0]  rdata0_o,
  output logic [LLR_W-1:0]  rdata1_o
);
  localparam int unsigned DEPTH = 1 << CODE_W;

  logic [2*LLR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= {wdata0_i, wdata1_i};
  end

  // read is combinational; a same-cycle write is seen from the next cycle
  assign rdata0_o = mem_q[raddr_i][2*LLR_W-1:LLR_W];
  assign rdata1_o = mem_q[raddr_i][LLR_W-1:0];
endmodule

// File: rtl/llr_erase.sv
module llr_erase #(
  parameter int unsigned LLR_W = 8
) (
  input  logic [LLR_W-1:0] llr_i,
  input  logic             stuck_i,
  input  llr_pkg::erase_mode_e mode_i,
  input  logic [LLR_W-1:0] bias_i,
  output logic [LLR_W-1:0] llr_o
);
  localparam logic [LLR_W-1:0] NEG_MIN = {1'b1, {(LLR_W-1){1'b0}}};
  localparam logic [LLR_W-1:0] NEG_SAT = {1'b1, {(LLR_W-2){1'b0}}, 1'b1};

  logic [LLR_W-1:0] sel;

  always_comb begin
    if (!stuck_i)                         sel = llr_i;
    else if (mode_i == llr_pkg::ERASE_BIAS) sel = bias_i;
    else                                  sel = '0;
    llr_o = (sel == NEG_MIN) ? NEG_SAT : sel;
  end
endmodule

// File: rtl/llr_serializer.sv
module llr_serializer #(
  parameter int unsigned LLR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [LLR_W-1:0] in_b0_i,
  input  logic [LLR_W-1:0] in_b1_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [LLR_W-1:0] out_llr_o,
  output logic             out_bit_o
);
  logic             full_q, phase_q;
  logic [LLR_W-1:0] b0_q, b1_q;
  logic             fire, accept;

  assign fire       = full_q & out_ready_i;
  assign in_ready_o = ~full_q | (fire & phase_q);
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      phase_q <= 1'b0;
      b0_q    <= '0;
      b1_q    <= '0;
    end else if (accept) begin
      full_q  <= 1'b1;
      phase_q <= 1'b0;
      b0_q    <= in_b0_i;
      b1_q    <= in_b1_i;
    end else if (fire) begin
      full_q  <= ~phase_q;
      phase_q <= ~phase_q;
    end
  end

  assign out_valid_o = full_q;
  assign out_bit_o   = phase_q;
  assign out_llr_o   = phase_q ? b1_q : b0_q;
endmodule

// File: rtl/llr_erase_gen.sv
module llr_erase_gen #(
  parameter int unsigned CODE_W = llr_pkg::CODE_W_DEF,
  parameter int unsigned LLR_W  = llr_pkg::LLR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_start_i,
  input  logic              bias_en_i,
  input  logic [LLR_W-1:0]  bias_val_i,
  input  logic              lut_we_i,
  input  logic [CODE_W-1:0] lut_addr_i,
  input  logic [LLR_W-1:0]  lut_llr0_i,
  input  logic [LLR_W-1:0]  lut_llr1_i,
  input  logic              cell_valid_i,
  output logic              cell_ready_o,
  input  logic [CODE_W-1:0] cell_code_i,
  input  logic              cell_stuck_i,
  output logic              llr_valid_o,
  input  logic              llr_ready_i,
  output logic [LLR_W-1:0]  llr_o,
  output logic              llr_bit_o
);
  import llr_pkg::*;

  localparam int unsigned NBITS = 2;

  erase_mode_e      mode_q, mode_eff;
  logic [LLR_W-1:0] bias_q, bias_eff;
  logic [LLR_W-1:0] raw   [NBITS];
  logic [LLR_W-1:0] clean [NBITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ERASE_ZERO;
      bias_q <= '0;
    end else if (page_start_i) begin
      mode_q <= erase_mode_e'(bias_en_i);
      bias_q <= bias_val_i;
    end
  end

  // first cell of a page uses the setting presented with the page start
  assign mode_eff = page_start_i ? erase_mode_e'(bias_en_i) : mode_q;
  assign bias_eff = page_start_i ? bias_val_i : bias_q;

  llr_lut #(.CODE_W(CODE_W), .LLR_W(LLR_W)) u_lut (
    .clk_i    (clk_i),
    .we_i     (lut_we_i),
    .waddr_i  (lut_addr_i),
    .wdata0_i (lut_llr0_i),
    .wdata1_i (lut_llr1_i),
    .raddr_i  (cell_code_i),
    .rdata0_o (raw[0]),
    .rdata1_o (raw[1])
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    llr_erase #(.LLR_W(LLR_W)) u_erase (
      .llr_i   (raw[b]),
      .stuck_i (cell_stuck_i),
      .mode_i  (mode_eff),
      .bias_i  (bias_eff),
      .llr_o   (clean[b])
    );
  end

  llr_serializer #(.LLR_W(LLR_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (cell_valid_i),
    .in_ready_o  (cell_ready_o),
    .in_b0_i     (clean[0]),
    .in_b1_i     (clean[1]),
    .out_valid_o (llr_valid_o),
    .out_ready_i (llr_ready_i),
    .out_llr_o   (llr_o),
    .out_bit_o   (llr_bit_o)
  );
endmodule

// File: rtl/llr_erase_gen_chk.sv
module llr_erase_gen_chk #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned LLR_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              page_start_i,
  input logic              bias_en_i,
  input logic [LLR_W-1:0]  bias_val_i,
  input logic              lut_we_i,
  input logic [CODE_W-1:0] lut_addr_i,
  input logic [LLR_W-1:0]  lut_llr0_i,
  input logic [LLR_W-1:0]  lut_llr1_i,
  input logic              cell_valid_i,
  input logic              cell_ready_o,
  input logic [CODE_W-1:0] cell_code_i,
  input logic              cell_stuck_i,
  input logic              llr_valid_o,
  input logic              llr_ready_i,
  input logic [LLR_W-1:0]  llr_o,
  input logic              llr_bit_o
);
  localparam logic [LLR_W-1:0] NEG_MIN = {1'b1, {(LLR_W-1){1'b0}}};

  p_no_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    llr_valid_o |-> (llr_o != NEG_MIN));

  p_second_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (llr_valid_o && llr_ready_i && !llr_bit_o) |=> (llr_valid_o && llr_bit_o));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (llr_valid_o && llr_ready_i && llr_bit_o) |=> !llr_bit_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (llr_valid_o && !llr_ready_i) |=>
      (llr_valid_o && $stable(llr_o) && $stable(llr_bit_o)));

  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_ready_o |-> llr_valid_o);
endmodule

bind llr_erase_gen llr_erase_gen_chk #(.CODE_W(CODE_W), .LLR_W(LLR_W)) u_chk (.*);

// File: tb/sim_llr_erase_gen.sv
`timescale 1ns/1ps
module sim_llr_erase_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       page_start = 1'b0, bias_en = 1'b0;
  logic [7:0] bias_val = '0;
  logic       lut_we = 1'b0;
  logic [5:0] lut_addr = '0;
  logic [7:0] lut0 = '0, lut1 = '0;
  logic       cvalid = 1'b0, cstuck = 1'b0;
  logic [5:0] ccode = '0;
  logic       cready, lvalid, lbit;
  logic       lready = 1'b1;
  logic [7:0] llr;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  llr_erase_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .page_start_i(page_start),
    .bias_en_i(bias_en), .bias_val_i(bias_val),
    .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_llr0_i(lut0), .lut_llr1_i(lut1),
    .cell_valid_i(cvalid), .cell_ready_o(cready), .cell_code_i(ccode),
    .cell_stuck_i(cstuck), .llr_valid_o(lvalid), .llr_ready_i(lready),
    .llr_o(llr), .llr_bit_o(lbit)
  );

  function automatic int t0(int c); return int'($signed(8'(c * 4 + 128))); endfunction
  function automatic int t1(int c); return int'($signed(8'(100 - c * 3))); endfunction
  function automatic int sat(int v); return (v == -128) ? -127 : v; endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sllr(); return int'($signed(llr)); endfunction

  // drive cell at negedge, accept at posedge, read both bits
  task automatic run_cell(input string req, input int code, input bit stuck,
                          input int e0, input int e1);
    @(negedge clk);
    cvalid = 1'b1; ccode = 6'(code); cstuck = stuck;
    @(posedge clk);
    @(negedge clk);
    cvalid = 1'b0;
    check({req, " valid"}, int'(lvalid), 1);
    check({req, " bit0 pos"}, int'(lbit), 0);
    check({req, " bit0"}, sllr(), e0);
    @(negedge clk);
    check({req, " bit1 pos"}, int'(lbit), 1);
    check({req, " bit1"}, sllr(), e1);
    @(negedge clk);
    check({req, " idle"}, int'(lvalid), 0);
  endtask

  task automatic set_page(input bit en, input int val);
    @(negedge clk);
    page_start = 1'b1; bias_en = en; bias_val = 8'(val);
    @(negedge clk);
    page_start = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R8 valid", int'(lvalid), 0);
    check("R8 ready", int'(cready), 1);
  endtask

  task automatic load_lut();
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_addr = 6'(c); lut0 = 8'(t0(c)); lut1 = 8'(t1(c));
    end
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic test_pass();
    run_cell("R1 code0 R2", 0, 1'b0, sat(t0(0)), sat(t1(0)));
    run_cell("R1 code17", 17, 1'b0, sat(t0(17)), sat(t1(17)));
    run_cell("R1 code63", 63, 1'b0, sat(t0(63)), sat(t1(63)));
    run_cell("R1 code40", 40, 1'b0, sat(t0(40)), sat(t1(40)));
  endtask

  task automatic test_erase();
    run_cell("R8 R3 default zero", 63, 1'b1, 0, 0);
    set_page(1'b1, 40);
    run_cell("R4 bias", 10, 1'b1, 40, 40);
    run_cell("R4 unstuck passes", 10, 1'b0, sat(t0(10)), sat(t1(10)));
    @(negedge clk);
    bias_en = 1'b0; bias_val = 8'(-5);
    run_cell("R5 no page start", 20, 1'b1, 40, 40);
    set_page(1'b0, 77);
    run_cell("R3 zero again", 20, 1'b1, 0, 0);
  endtask

  // page start in the same cycle as a stuck cell, bias at the negative limit
  task automatic test_page_same_cycle();
    @(negedge clk);
    page_start = 1'b1; bias_en = 1'b1; bias_val = 8'h80;
    cvalid = 1'b1; ccode = 6'd3; cstuck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    page_start = 1'b0; cvalid = 1'b0;
    check("R5 same-cycle bit0 R2", sllr(), -127);
    @(negedge clk);
    check("R5 same-cycle bit1 R4", sllr(), -127);
    @(negedge clk);
    set_page(1'b0, 0);
  endtask

  task automatic test_lut_same_cycle();
    @(negedge clk);
    lut_we = 1'b1; lut_addr = 6'd5; lut0 = 8'd33; lut1 = 8'(-44);
    cvalid = 1'b1; ccode = 6'd5; cstuck = 1'b0;
    @(posedge clk);
    @(negedge clk);
    lut_we = 1'b0; cvalid = 1'b0;
    check("R9 old bit0", sllr(), sat(t0(5)));
    @(negedge clk);
    check("R9 old bit1", sllr(), sat(t1(5)));
    @(negedge clk);
    run_cell("R9 new", 5, 1'b0, 33, -44);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    lready = 1'b0;
    cvalid = 1'b1; ccode = 6'd30; cstuck = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ccode = 6'd31;  // second cell stays offered
    for (int i = 0; i < 3; i++) begin
      check("R7 hold ready low", int'(cready), 0);
      check("R7 hold bit", int'(lbit), 0);
      check("R7 hold value", sllr(), sat(t0(30)));
      @(negedge clk);
    end
    lready = 1'b1;
    @(negedge clk);
    check("R6 bit1 after stall", int'(lbit), 1);
    check("R7 first bit1", sllr(), sat(t1(30)));
    check("R7 ready on last", int'(cready), 1);
    @(posedge clk);
    @(negedge clk);
    cvalid = 1'b0;
    check("R7 second bit0", sllr(), sat(t0(31)));
    check("R6 second pos", int'(lbit), 0);
    @(negedge clk);
    check("R7 second bit1", sllr(), sat(t1(31)));
    @(negedge clk);
    check("R7 drained", int'(lvalid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    load_lut();
    test_erase();
    test_pass();
    test_page_same_cycle();
    test_lut_same_cycle();
    test_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule